// File: doc/BRIEF.md
# Stereo 3D Sprite Interleaver

This block merges the pixel streams of two sprite planes, called A and B, into one stream for a stereoscopic display. The two planes arrive in lockstep: they share start-of-line and start-of-frame markers, and each plane has its own valid flag. Each cycle in which either valid flag is high is one pixel slot.

A two-bit format field selects how the output is built from the two planes. In the pass-through format, plane A is sent on unchanged. In the line format, whole lines alternate between the planes. In the pixel format, pixels within a line alternate between the planes. An order bit chooses which plane supplies the first line or the first pixel. The format field and the order bit are taken in only on the start-of-frame slot, so a frame keeps one pattern from its first pixel to its last.

The output is registered. It carries the chosen pixel, a valid flag and a flag that names the plane the pixel came from. Blending against other planes, scaling and memory fetch happen elsewhere.

Top module: `s3d_interleaver`

## Requirements
- R1: After reset, `out_valid` and `out_src` are 0, and the held format is pass-through with order 0 until the first start-of-frame slot.
- R2: The format code on `fmt_cfg` is 2'b00 for pass-through, 2'b01 for line, 2'b10 for pixel and 2'b11 reserved. Pass-through and reserved both send plane A for every slot (`out_src` = 0), whatever the order bit is.
- R3: With `order_cfg` = 0 plane A supplies the first line (line format) or the first pixel of each line (pixel format). With `order_cfg` = 1 plane B supplies it.
- R4: In line format the source toggles at each start-of-line slot and goes back to the starting plane at each start-of-frame slot.
- R5: In pixel format the source toggles on every slot within a line and goes back to the starting plane at each start-of-line or start-of-frame slot.
- R6: `fmt_cfg` and `order_cfg` are sampled only on a start-of-frame slot. A change at any other time has no effect until the next start-of-frame slot.
- R7: The output appears one cycle after its slot. `out_src` (0 = A, 1 = B) and `out_pix` belong to the same slot, and `out_valid` repeats the valid flag of the chosen plane.
- R8: A cycle in which neither valid flag is high is not a slot. It gives `out_valid` = 0, leaves `out_src` and `out_pix` unchanged, and does not move the alternation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| a_valid | input | 1 | Plane A pixel valid |
| a_pix | input | PIX_W | Plane A pixel |
| b_valid | input | 1 | Plane B pixel valid |
| b_pix | input | PIX_W | Plane B pixel |
| sol | input | 1 | Start of line, qualifies the current slot |
| sof | input | 1 | Start of frame, qualifies the current slot |
| fmt_cfg | input | 2 | Interleave format code |
| order_cfg | input | 1 | Starting plane: 0 = A, 1 = B |
| out_valid | output | 1 | Output pixel valid |
| out_pix | output | PIX_W | Output pixel |
| out_src | output | 1 | Source of the output pixel: 0 = A, 1 = B |

## Verification
The assertions check these rules on every cycle: the held configuration stays fixed away from start-of-frame slots, a cycle with no slot never gives a valid output, pass-through never reports plane B, and the first slot of a frame or line starts on the plane chosen by the order bit. Alternation across a whole line or frame, the return to the starting plane, and the point where a mid-frame configuration change takes effect depend on long histories. Only the bench's behavioural model can show these, by comparing against the outputs in every cycle.

// File: rtl/s3d_pkg.sv
package s3d_pkg;

  typedef enum logic [1:0] {
    FMT_PASS  = 2'b00,
    FMT_LINE  = 2'b01,
    FMT_PIXEL = 2'b10,
    FMT_RSVD  = 2'b11
  } s3d_fmt_e;

  // Source for one slot: 0 = plane A, 1 = plane B.
  function automatic logic s3d_pick(input s3d_fmt_e fmt, input logic ord,
                                    input logic line_ph, input logic pix_ph);
    logic r;
    case (fmt)
      FMT_LINE:  r = ord ^ line_ph;
      FMT_PIXEL: r = ord ^ pix_ph;
      default:   r = 1'b0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/s3d_cfg_hold.sv
module s3d_cfg_hold
  import s3d_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     slot,
  input  logic     sof,
  input  logic [1:0] fmt_cfg,
  input  logic     order_cfg,
  output s3d_fmt_e eff_fmt,
  output logic     eff_ord
);
  s3d_fmt_e fmt_q;
  logic     ord_q;
  logic     take;

  assign take = slot & sof;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fmt_q <= FMT_PASS;
      ord_q <= 1'b0;
    end else if (take) begin
      fmt_q <= s3d_fmt_e'(fmt_cfg);
      ord_q <= order_cfg;
    end
  end

  // The start-of-frame slot already uses the new settings.
  assign eff_fmt = take ? s3d_fmt_e'(fmt_cfg) : fmt_q;
  assign eff_ord = take ? order_cfg : ord_q;

  p_cfg_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> ($stable(fmt_q) && $stable(ord_q)));

endmodule

// File: rtl/s3d_phase.sv
module s3d_phase (
  input  logic clk,
  input  logic rst_n,
  input  logic slot,
  input  logic sol,
  input  logic sof,
  output logic line_ph,
  output logic pix_ph
);
  logic line_q, pix_q;

  always_comb begin
    if (sof)      line_ph = 1'b0;
    else if (sol) line_ph = ~line_q;
    else          line_ph = line_q;
    pix_ph = (sol | sof) ? 1'b0 : ~pix_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_q <= 1'b0;
      pix_q  <= 1'b1;
    end else if (slot) begin
      line_q <= line_ph;
      pix_q  <= pix_ph;
    end
  end

  p_phase_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !slot |=> ($stable(line_q) && $stable(pix_q)));

endmodule

// File: rtl/s3d_out_stage.sv
module s3d_out_stage #(
  parameter int PIX_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             slot,
  input  logic             sel,
  input  logic             a_valid,
  input  logic [PIX_W-1:0] a_pix,
  input  logic             b_valid,
  input  logic [PIX_W-1:0] b_pix,
  output logic             out_valid,
  output logic [PIX_W-1:0] out_pix,
  output logic             out_src
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_pix   <= '0;
      out_src   <= 1'b0;
    end else begin
      out_valid <= slot & (sel ? b_valid : a_valid);
      if (slot) begin
        out_pix <= sel ? b_pix : a_pix;
        out_src <= sel;
      end
    end
  end

  p_no_slot_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !slot |=> (!out_valid && $stable(out_src) && $stable(out_pix)));

endmodule

// File: rtl/s3d_interleaver.sv
module s3d_interleaver
  import s3d_pkg::*;
#(
  parameter int PIX_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             a_valid,
  input  logic [PIX_W-1:0] a_pix,
  input  logic             b_valid,
  input  logic [PIX_W-1:0] b_pix,
  input  logic             sol,
  input  logic             sof,
  input  logic [1:0]       fmt_cfg,
  input  logic             order_cfg,
  output logic             out_valid,
  output logic [PIX_W-1:0] out_pix,
  output logic             out_src
);
  // Named internal events for the assertions.
  logic     slot;
  s3d_fmt_e eff_fmt;
  logic     eff_ord;
  logic     line_ph, pix_ph;
  logic     sel;
  logic     is_pass;

  assign slot = a_valid | b_valid;

  s3d_cfg_hold u_cfg (
    .clk(clk), .rst_n(rst_n), .slot(slot), .sof(sof),
    .fmt_cfg(fmt_cfg), .order_cfg(order_cfg),
    .eff_fmt(eff_fmt), .eff_ord(eff_ord)
  );

  s3d_phase u_phase (
    .clk(clk), .rst_n(rst_n), .slot(slot), .sol(sol), .sof(sof),
    .line_ph(line_ph), .pix_ph(pix_ph)
  );

  assign sel     = s3d_pick(eff_fmt, eff_ord, line_ph, pix_ph);
  assign is_pass = (eff_fmt == FMT_PASS) || (eff_fmt == FMT_RSVD);

  s3d_out_stage #(.PIX_W(PIX_W)) u_out (
    .clk(clk), .rst_n(rst_n), .slot(slot), .sel(sel),
    .a_valid(a_valid), .a_pix(a_pix), .b_valid(b_valid), .b_pix(b_pix),
    .out_valid(out_valid), .out_pix(out_pix), .out_src(out_src)
  );

  p_pass_is_a_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (slot && is_pass) |=> !out_src);

  p_first_line_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (slot && sof && fmt_cfg == 2'b01) |=> (out_src == $past(order_cfg)));

  p_first_pixel_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (slot && (sol || sof) && eff_fmt == FMT_PIXEL) |=> (out_src == $past(eff_ord)));

  p_valid_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (slot && a_valid && b_valid) |=> out_valid);

endmodule

// File: tb/tb_s3d_interleaver.sv
module tb_s3d_interleaver;
  localparam int PW = 24;

  logic clk = 1'b0;
  logic rst_n;
  logic a_valid, b_valid, sol, sof, order_cfg;
  logic [PW-1:0] a_pix, b_pix;
  logic [1:0] fmt_cfg;
  logic out_valid, out_src;
  logic [PW-1:0] out_pix;

  int checks = 0;
  int errors = 0;
  string tag = "R7";

  // Reference model state
  int m_fmt = 0, m_ord = 0, m_line = 0, m_pix = 0;
  bit exp_v = 0, exp_src = 0;
  logic [PW-1:0] exp_pix = '0;
  bit armed = 0;

  always #5 clk = ~clk;

  s3d_interleaver #(.PIX_W(PW)) dut (
    .clk(clk), .rst_n(rst_n), .a_valid(a_valid), .a_pix(a_pix),
    .b_valid(b_valid), .b_pix(b_pix), .sol(sol), .sof(sof),
    .fmt_cfg(fmt_cfg), .order_cfg(order_cfg),
    .out_valid(out_valid), .out_pix(out_pix), .out_src(out_src)
  );

  task automatic check(input string req, input logic [PW-1:0] act,
                       input logic [PW-1:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h t=%0t", req, what, act, exp, $time);
    end
  endtask

  // One cycle: check the previous slot's output, then drive a new slot.
  task automatic step(input bit av, input bit bv, input bit sl, input bit sf,
                      input int fm, input bit od);
    bit sel;
    @(negedge clk);
    if (armed) begin
      check(tag, PW'(out_valid), PW'(exp_v), "out_valid");
      if (exp_v) begin
        check(tag, PW'(out_src), PW'(exp_src), "out_src");
        check("R7", out_pix, exp_pix, "out_pix");
      end
    end
    a_valid = av; b_valid = bv; sol = sl; sof = sf;
    fmt_cfg = fm[1:0]; order_cfg = od;
    a_pix = {8'hA0, 8'(m_line), 8'(m_pix)};
    b_pix = {8'hB0, 8'(m_line), 8'(m_pix)};
    if (av || bv) begin
      if (sf) begin m_fmt = fm; m_ord = od; m_line = 0; m_pix = 0; end
      else if (sl) begin m_line++; m_pix = 0; end
      else m_pix++;
      if (m_fmt == 1)      sel = bit'((m_ord + m_line) % 2);
      else if (m_fmt == 2) sel = bit'((m_ord + m_pix) % 2);
      else                 sel = 0;
      exp_v   = sel ? bv : av;
      exp_src = sel;
      exp_pix = sel ? b_pix : a_pix;
    end else begin
      exp_v = 0;
    end
    armed = 1;
  endtask

  task automatic frame(input int fm, input bit od, input int lines, input int pixels,
                       input bit gaps);
    for (int l = 0; l < lines; l++)
      for (int p = 0; p < pixels; p++) begin
        if (gaps && p == 2) step(0, 0, 0, 0, fm, od);
        step(1, 1, p == 0, (l == 0 && p == 0), fm, od);
      end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 0; a_valid = 0; b_valid = 0; sol = 0; sof = 0;
    fmt_cfg = 2'b10; order_cfg = 1; a_pix = '0; b_pix = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    // R1: reset state
    check("R1", PW'(out_valid), '0, "out_valid after reset");
    check("R1", PW'(out_src), '0, "out_src after reset");
    // R1: before any frame start, pixel code on pins is not yet used
    tag = "R1";
    step(1, 1, 1, 0, 2, 1); step(1, 1, 0, 0, 2, 1); step(1, 1, 0, 0, 2, 1);
    // R2: pass-through and reserved codes ignore order
    tag = "R2"; frame(0, 1, 2, 4, 0);
    frame(3, 1, 2, 4, 0);
    // R3 / R4: line format, both orders
    tag = "R4"; frame(1, 0, 4, 3, 0);
    tag = "R3"; frame(1, 1, 4, 3, 0);
    // R5: pixel format, both orders, restart per line
    tag = "R5"; frame(2, 0, 3, 5, 0);
    frame(2, 1, 3, 5, 0);
    // R8: idle gaps do not move the alternation
    tag = "R8"; frame(2, 0, 2, 5, 1);
    frame(1, 1, 3, 4, 1);
    // R6: config changes mid-frame are ignored until next frame start
    tag = "R6";
    step(1, 1, 1, 1, 2, 0);
    step(1, 1, 0, 0, 1, 1); step(1, 1, 0, 0, 0, 1); step(1, 1, 1, 0, 3, 1);
    step(1, 1, 0, 0, 1, 0); step(1, 1, 0, 0, 1, 0);
    step(1, 1, 1, 1, 1, 0); step(1, 1, 0, 0, 2, 1); step(1, 1, 1, 0, 2, 1);
    // R7: only one plane valid, output valid follows the chosen plane
    tag = "R7";
    step(1, 0, 1, 1, 2, 0); step(1, 0, 0, 0, 2, 0); step(0, 1, 0, 0, 2, 0);
    step(0, 1, 0, 0, 2, 0); step(1, 0, 1, 0, 2, 0);
    step(0, 0, 0, 0, 2, 0); step(0, 0, 0, 0, 2, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule